// File: doc/BRIEF.md
# Keyboard Scan and Interrupt Controller

This block walks a key matrix one row group at a time and reports a pressed key to a small processor through a vectored interrupt. A 3-bit row count advances on a slow scan tick and is presented continuously so that external logic can decode it into row enables. Four active-high column lines are sampled on each tick. When a column is active on a tick, the row count freezes, a 5-bit key address is formed from the frozen row and the encoded column, and a keyboard interrupt flag is latched.

The keyboard flag and three further level-sensitive interrupt sources, which may be tied low when unused, are priority-encoded into a 4-bit vector. A single request output is raised while any source is active. While the processor holds acknowledge, the vector and the key word are driven onto the response bus with its enable set. The acknowledge clears the keyboard flag. Scanning restarts only after the columns have been quiet on two consecutive scan ticks.

Top module: `kbd_scan_intc`

## Requirements
- R1: After a synchronous active-low reset, row_out is 0, key_det is 0, int_req is 0 when ext_int is 0, bus_oe is 0 and bus_data is 0.
- R2: With no column active, each scan_tick pulse advances row_out by one, wrapping from 7 to 0; row_out does not change on cycles without scan_tick.
- R3: A scan_tick while any column is active freezes row_out at its current value and sets key_det; further ticks leave row_out unchanged while key_det is 1.
- R4: The key word is 8 bits: bits [4:2] hold the frozen row, bits [1:0] hold the index of the lowest-numbered active column (col_in[0] is index 0), and bits [7:5] are 0.
- R5: A captured keypress latches the keyboard flag, which is interrupt input 0, so int_req goes to 1 in the cycle after the capturing tick.
- R6: Interrupt input 0 (keyboard flag) has the highest priority and input 3 (ext_int[2]) the lowest; the vector is the index of the highest-priority active input, and int_req is 1 while any input is active.
- R7: While int_ack is 1, bus_oe is 1 and bus_data is {vector[3:0], key word[7:0]}; while int_ack is 0, bus_oe is 0 and bus_data is 0.
- R8: A cycle with int_ack high clears the keyboard flag at the following clock edge unless a new capture happens at that same edge.
- R9: While key_det is 1, key_det clears on the second of two consecutive scan ticks with every column inactive; a tick with a column active restarts that count; row_out is unchanged by the release and advances again from the next tick.
- R10: ext_int inputs (interrupt inputs 1 to 3, ext_int[0] is input 1) raise int_req without affecting scanning or the key word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_tick | input | 1 | One-cycle pulse that paces the row scan |
| col_in | input | 4 | Active-high column lines for the enabled row group |
| ext_int | input | 3 | Level interrupt sources 1 to 3 |
| int_ack | input | 1 | Processor interrupt acknowledge |
| row_out | output | 3 | Current row count for the external row decoder |
| key_det | output | 1 | High while scanning is frozen on a key |
| int_req | output | 1 | Interrupt request to the processor |
| bus_oe | output | 1 | Response bus drive enable |
| bus_data | output | 12 | Vector and key word during acknowledge |

## Verification
The scan is tried with idle columns across a full wrap of the row count, which separates a correct modulo-8 step from a stuck or skipping counter, and with ticks withheld, which shows the counter moves only on the tick. Keypresses on different rows with single and multiple active columns separate a correct lowest-column encode and row capture from a wrong field order. Release sequences with an active tick placed between quiet ticks tell a true consecutive-quiet count from a cumulative one, and mixed keyboard and external sources tell the priority order apart from its reverse.

// File: rtl/kbd_pkg.sv
// Package: shared parameters and types for the keyboard scan and interrupt block.
package kbd_pkg;
    localparam int ROW_W   = 3;
    localparam int COL_N   = 4;
    localparam int COL_W   = $clog2(COL_N);
    localparam int KEY_W   = 8;
    localparam int INT_N   = 4;
    localparam int VEC_W   = 4;

    typedef enum logic {SC_RUN = 1'b0, SC_HOLD = 1'b1} scan_state_t;
endpackage

// File: rtl/kbd_row_scanner.sv
// Module: kbd_row_scanner
// Steps the row count on scan ticks, freezes it when a column is active on a
// tick, captures the key word and waits for QUIET_TICKS consecutive idle ticks
// before resuming. Assumes col_in is already debounced and synchronous to clk.
module kbd_row_scanner
    import kbd_pkg::*;
#(
    parameter int QUIET_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_tick,
    input  logic [COL_N-1:0] col_in,
    output logic [ROW_W-1:0] row,
    output logic             held,
    output logic             capture,
    output logic [KEY_W-1:0] key_word
);
    localparam int QW = $clog2(QUIET_TICKS + 1);
    localparam int PAD_W = KEY_W - ROW_W - COL_W;

    scan_state_t          state;
    logic [QW-1:0]        quiet_cnt;
    logic [COL_W-1:0]     col_idx;
    logic                 any_col;

    // Encode the lowest-numbered active column.
    always_comb begin
        col_idx = '0;
        for (int i = COL_N - 1; i >= 0; i--) begin
            if (col_in[i]) col_idx = COL_W'(i);
        end
    end

    assign any_col = |col_in;
    assign capture = scan_tick && (state == SC_RUN) && any_col;
    assign held    = (state == SC_HOLD);

    // Row stepping, key capture and quiet-tick release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SC_RUN;
            row       <= '0;
            quiet_cnt <= '0;
            key_word  <= '0;
        end else if (scan_tick) begin
            case (state)
                SC_RUN: begin
                    if (any_col) begin
                        state     <= SC_HOLD;
                        quiet_cnt <= '0;
                        key_word  <= {{PAD_W{1'b0}}, row, col_idx};
                    end else begin
                        row <= row + 1'b1;
                    end
                end
                default: begin
                    if (any_col) begin
                        quiet_cnt <= '0;
                    end else if (quiet_cnt == QW'(QUIET_TICKS - 1)) begin
                        state     <= SC_RUN;
                        quiet_cnt <= '0;
                    end else begin
                        quiet_cnt <= quiet_cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // R2: an idle tick while running steps the row by one.
    a_r2_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_tick && !held && !any_col) |=> (row == $past(row) + 1'b1));

    // R3: the row never moves while frozen.
    a_r3_row_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> (row == $past(row)));

    // R4: a fresh capture records the current row in the key word.
    a_r4_key_row: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (key_word[COL_W +: ROW_W] == row));
endmodule

// File: rtl/kbd_int_prio.sv
// Module: kbd_int_prio
// Holds the keyboard interrupt flag (input 0) and priority-encodes it with the
// external level sources into a vector; input 0 wins. Assumes external
// sources are synchronous and clear themselves.
module kbd_int_prio
    import kbd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kbd_set,
    input  logic             int_ack,
    input  logic [INT_N-2:0] ext_int,
    output logic [VEC_W-1:0] vector,
    output logic             int_req
);
    logic             kbd_flag;
    logic [INT_N-1:0] srcs;

    // Keyboard flag: set on capture, cleared by acknowledge; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)        kbd_flag <= 1'b0;
        else if (kbd_set)  kbd_flag <= 1'b1;
        else if (int_ack)  kbd_flag <= 1'b0;
    end

    assign srcs = {ext_int, kbd_flag};

    // Vector is the index of the lowest-numbered active source.
    always_comb begin
        vector = '0;
        for (int i = INT_N - 1; i >= 0; i--) begin
            if (srcs[i]) vector = VEC_W'(i);
        end
    end

    assign int_req = |srcs;

    // R5: a capture raises the request on the next cycle.
    a_r5_req_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_set |=> (int_req && vector == '0));

    // R8: acknowledge without a new capture drops the keyboard flag.
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !kbd_set && ext_int == '0) |=> !int_req);
endmodule

// File: rtl/kbd_bus_mux.sv
// Module: kbd_bus_mux
// Places the vector and key word on the response bus while acknowledge is
// high and releases the bus (enable low, data zero) otherwise.
module kbd_bus_mux
    import kbd_pkg::*;
(
    input  logic                   int_ack,
    input  logic [VEC_W-1:0]       vector,
    input  logic [KEY_W-1:0]       key_word,
    output logic                   bus_oe,
    output logic [VEC_W+KEY_W-1:0] bus_data
);
    // Gate the response word with acknowledge.
    always_comb begin
        bus_oe   = int_ack;
        bus_data = int_ack ? {vector, key_word} : '0;
    end
endmodule

// File: rtl/kbd_scan_intc.sv
// Module: kbd_scan_intc (top)
// Keyboard row scanner with vectored interrupt response. Assumes scan_tick is
// a single-cycle pulse and all inputs are synchronous to clk.
module kbd_scan_intc
    import kbd_pkg::*;
#(
    parameter int QUIET_TICKS = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scan_tick,
    input  logic [COL_N-1:0]       col_in,
    input  logic [INT_N-2:0]       ext_int,
    input  logic                   int_ack,
    output logic [ROW_W-1:0]       row_out,
    output logic                   key_det,
    output logic                   int_req,
    output logic                   bus_oe,
    output logic [VEC_W+KEY_W-1:0] bus_data
);
    logic             capture;
    logic [KEY_W-1:0] key_word;
    logic [VEC_W-1:0] vector;

    kbd_row_scanner #(.QUIET_TICKS(QUIET_TICKS)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .scan_tick(scan_tick),
        .col_in   (col_in),
        .row      (row_out),
        .held     (key_det),
        .capture  (capture),
        .key_word (key_word)
    );

    kbd_int_prio u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .kbd_set (capture),
        .int_ack (int_ack),
        .ext_int (ext_int),
        .vector  (vector),
        .int_req (int_req)
    );

    kbd_bus_mux u_bus (
        .int_ack (int_ack),
        .vector  (vector),
        .key_word(key_word),
        .bus_oe  (bus_oe),
        .bus_data(bus_data)
    );

    // R7: an enabled bus never carries a vector outside the source range.
    a_r7_bus_vector: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (bus_data[KEY_W +: VEC_W] < VEC_W'(INT_N)));

    // R9: leaving the frozen state happens only on a tick with idle columns.
    a_r9_release_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (key_det && !(scan_tick && col_in == '0)) |=> key_det);
endmodule

// File: tb/kbd_scan_intc_tb.sv
module kbd_scan_intc_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        scan_tick;
    logic [3:0]  col_in;
    logic [2:0]  ext_int;
    logic        int_ack;
    logic [2:0]  row_out;
    logic        key_det;
    logic        int_req;
    logic        bus_oe;
    logic [11:0] bus_data;

    int n_chk  = 0;
    int n_fail = 0;
    logic [2:0] exp_row;

    kbd_scan_intc u_dut (
        .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .col_in(col_in),
        .ext_int(ext_int), .int_ack(int_ack), .row_out(row_out),
        .key_det(key_det), .int_req(int_req), .bus_oe(bus_oe),
        .bus_data(bus_data)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock with optional tick; ends at negedge.
    task automatic step(input logic tick);
        scan_tick = tick;
        @(posedge clk);
        @(negedge clk);
        scan_tick = 1'b0;
    endtask

    // Acknowledge for one cycle; checks bus while held.
    task automatic ack_cycle(input logic [11:0] exp_bus, input string req);
        int_ack = 1'b1;
        #1;
        chk(req, {31'd0, bus_oe}, 32'd1);
        chk(req, {20'd0, bus_data}, {20'd0, exp_bus});
        @(posedge clk);
        @(negedge clk);
        int_ack = 1'b0;
        #1;
        chk("R7", {31'd0, bus_oe}, 32'd0);
        chk("R7", {20'd0, bus_data}, 32'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; scan_tick = 1'b0; col_in = 4'h0; ext_int = 3'h0; int_ack = 1'b0;
        step(1'b0); step(1'b0);
        rst_n = 1'b1;
        step(1'b0);
        exp_row = 3'd0;
        chk("R1", {29'd0, row_out}, 32'd0);
        chk("R1", {31'd0, key_det}, 32'd0);
        chk("R1", {31'd0, int_req}, 32'd0);
        chk("R1", {31'd0, bus_oe}, 32'd0);
        chk("R1", {20'd0, bus_data}, 32'd0);
    endtask

    task automatic t_scan_wrap();
        for (int i = 0; i < 10; i++) begin
            step(1'b1);
            exp_row = exp_row + 3'd1;
            chk("R2", {29'd0, row_out}, {29'd0, exp_row});
            step(1'b0);
            chk("R2 no tick", {29'd0, row_out}, {29'd0, exp_row});
        end
    endtask

    // Press a key on the current row and acknowledge it.
    task automatic t_press(input logic [3:0] cols, input logic [1:0] idx);
        col_in = cols;
        step(1'b1);
        chk("R3", {29'd0, row_out}, {29'd0, exp_row});
        chk("R3", {31'd0, key_det}, 32'd1);
        chk("R5", {31'd0, int_req}, 32'd1);
        step(1'b1);
        step(1'b1);
        chk("R3 held", {29'd0, row_out}, {29'd0, exp_row});
        ack_cycle({4'h0, 3'b000, exp_row, idx}, "R4");
        chk("R8", {31'd0, int_req}, 32'd0);
    endtask

    task automatic t_release();
        step(1'b1);
        chk("R9", {31'd0, key_det}, 32'd1);
        col_in = 4'h0;
        step(1'b1);
        chk("R9 one quiet", {31'd0, key_det}, 32'd1);
        col_in = 4'h2;
        step(1'b1);
        chk("R9 restart", {31'd0, key_det}, 32'd1);
        col_in = 4'h0;
        step(1'b1);
        chk("R9 one quiet", {31'd0, key_det}, 32'd1);
        step(1'b1);
        chk("R9 released", {31'd0, key_det}, 32'd0);
        chk("R9 row kept", {29'd0, row_out}, {29'd0, exp_row});
        step(1'b1);
        exp_row = exp_row + 3'd1;
        chk("R9 resume", {29'd0, row_out}, {29'd0, exp_row});
    endtask

    task automatic t_prio();
        logic [7:0] kw;
        kw = {3'b000, exp_row, 2'd3};
        ext_int = 3'b110;
        #1;
        chk("R10", {31'd0, int_req}, 32'd1);
        step(1'b1);
        exp_row = exp_row + 3'd1;
        chk("R10 scan", {29'd0, row_out}, {29'd0, exp_row});
        // Key word is still from the last capture (set below via press).
        col_in = 4'b1000;
        kw = {3'b000, exp_row, 2'd3};
        step(1'b1);
        chk("R6 kbd wins", {31'd0, int_req}, 32'd1);
        int_ack = 1'b1;
        #1;
        chk("R6", {20'd0, bus_data}, {20'd0, 4'd0, kw});
        @(posedge clk);
        @(negedge clk);
        int_ack = 1'b0;
        ack_cycle({4'd2, kw}, "R6");
        ext_int = 3'b100;
        ack_cycle({4'd3, kw}, "R6");
        ext_int = 3'b000;
        #1;
        chk("R6 none", {31'd0, int_req}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_scan_wrap();
        t_press(4'b0110, 2'd1);
        t_release();
        t_press(4'b1000, 2'd3);
        t_release();
        t_prio();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule